// File: doc/BRIEF.md
# Serial EEPROM Page-Write Staging Engine

This block is the byte-level write side of a two-wire serial EEPROM target. A bit-level front end that is not part of this block detects bus start and stop conditions and assembles bytes. It hands the block one-cycle start and stop pulses and one-cycle byte strobes. The block decodes the device-select byte and takes in a two-byte word address. It then places the data bytes that follow in a one-page staging buffer and answers every byte with an acknowledge or a not-acknowledge.

Nothing reaches the storage array while bytes are arriving. A stop after at least one data byte starts a timed internal program cycle. At the end of that cycle every staged byte is written to its page in one step. Slots of the page that were not received keep their old contents. While the cycle runs the block ignores the bus and refuses every byte, so a host can poll with start plus device select until it gets an acknowledge. The internal address counter is shown on `cur_addr_o`. A separate read path uses it together with the array read port `rd_addr_i`/`rd_data_o`.

Top module: `eeprom_page_writer`

## Requirements
- R1: A device-select byte received after a start, while not busy, is acknowledged (ack_o=1) when bits [7:1] equal parameter DEV_SEL and bit 0 is 0 (write). Any other select value is refused (ack_o=0) and ends the transfer. Every byte strobe is answered by ack_valid_o=1 in the following cycle.
- R2: After a write select, the next two bytes form the word address, high byte first and then low byte, and both are acknowledged. Bits of the high byte at positions ADDR_W-8 and above are ignored. Once the low byte is taken, cur_addr_o equals the ADDR_W-bit word address.
- R3: Each data byte is acknowledged and stored in page slot cur_addr_o[PAGE_W-1:0]. After the byte, those low PAGE_W bits step by one and wrap from the last slot to slot 0 of the same page, while cur_addr_o[ADDR_W-1:PAGE_W] stays fixed.
- R4: When more than 2**PAGE_W data bytes arrive in one transfer, a later byte for a slot replaces the earlier one, and only the last value for each slot is committed.
- R5: A stop that follows at least one data byte commits the staged bytes. The array shows the new contents from the cycle in which busy_o falls, and no array location changes before that stop.
- R6: Slots of the addressed page that received no data byte in the transfer keep their previous contents after the commit.
- R7: busy_o rises in the cycle after the committing stop is sampled and stays high for exactly WR_CYCLES cycles. After reset, busy_o, ack_valid_o and cur_addr_o are 0.
- R8: While busy_o is high, every byte is refused, start and stop are ignored, and cur_addr_o holds its value. A start plus write select issued after busy_o has fallen is acknowledged.
- R9: A stop or start that arrives before any data byte leaves the array unchanged, does not raise busy_o, and leaves cur_addr_o at the loaded word address.
- R10: A start that arrives after data bytes throws away the staged bytes. A later stop that does not follow new data bytes commits nothing.
- R11: A matching device-select byte with bit 0 = 1 (read) is acknowledged but starts no write. Bytes that follow it are refused until the next start.
- R12: Bytes that arrive with no transfer open, either after reset or after a stop, are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse: bus start (or repeated start) seen |
| stop_i | input | 1 | One-cycle pulse: bus stop seen |
| byte_valid_i | input | 1 | One-cycle strobe: byte_i holds a received byte |
| byte_i | input | 8 | Received byte, MSB first as assembled by the front end |
| ack_valid_o | output | 1 | High one cycle after each byte strobe |
| ack_o | output | 1 | Acknowledge (1) or refuse (0) for that byte, valid with ack_valid_o |
| busy_o | output | 1 | Internal program cycle running |
| cur_addr_o | output | ADDR_W | Internal word-address counter |
| rd_addr_i | input | ADDR_W | Array read address for the read path |
| rd_data_o | output | 8 | Array byte at rd_addr_i (combinational) |

## Verification
Several properties are checked on every cycle. Each byte strobe gets exactly one response, the following cycle. Every byte seen during busy is refused. The address counter stays frozen while busy. busy_o rises only after a stop and lasts exactly WR_CYCLES cycles. Each data byte advances only the in-page bits of the address. Whether the correct bytes land in the correct array slots needs the bench's scenarios to show it. These are: rollover overwrites, partial pages that preserve neighbours, aborted and discarded transfers, read selects, and polling that turns from refusal to acknowledge at a cycle the bench computes.

// File: rtl/eeprom_pw_pkg.sv
// Package: shared transfer-phase encoding for the page-write engine.
package eeprom_pw_pkg;

    // Position within one bus transfer, as tracked at byte level.
    typedef enum logic [2:0] {
        PH_IDLE,   // no transfer open, bytes are refused
        PH_SEL,    // expecting the device-select byte
        PH_AHI,    // expecting word-address high byte
        PH_ALO,    // expecting word-address low byte
        PH_DATA    // staging data bytes
    } xfer_phase_t;

endpackage

// File: rtl/eeprom_pw_ctrl.sv
// Byte-level transfer controller.
// Decodes device select and word address, steers data bytes into the page
// buffer, produces the per-byte acknowledge and requests a commit on stop.
// Assumes start_i, stop_i and byte_valid_i are never high in the same cycle,
// and ADDR_W lies between PAGE_W+1 and 16.
module eeprom_pw_ctrl
    import eeprom_pw_pkg::*;
#(
    parameter int unsigned ADDR_W  = 11,
    parameter int unsigned PAGE_W  = 6,
    parameter logic [6:0]  DEV_SEL = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    input  logic              busy_i,
    output logic              ack_valid_o,
    output logic              ack_o,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              data_phase_o,
    output logic              buf_clear_o,
    output logic              buf_we_o,
    output logic [PAGE_W-1:0] buf_slot_o,
    output logic [7:0]        buf_data_o,
    output logic              commit_o
);

    localparam logic [PAGE_W-1:0] SLOT_STEP = PAGE_W'(1);

    xfer_phase_t       phase_q;
    logic [7:0]        addr_hi_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              got_data_q;
    logic              live;
    logic [15:0]       word_addr;

    assign live      = !busy_i;
    assign word_addr = {addr_hi_q, byte_i};

    // Phase tracking, address capture, pointer stepping and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            addr_hi_q   <= '0;
            ptr_q       <= '0;
            got_data_q  <= 1'b0;
            ack_valid_o <= 1'b0;
            ack_o       <= 1'b0;
        end else begin
            ack_valid_o <= byte_valid_i;
            ack_o       <= 1'b0;
            if (live) begin
                if (stop_i) begin
                    phase_q    <= PH_IDLE;
                    got_data_q <= 1'b0;
                end else if (start_i) begin
                    phase_q    <= PH_SEL;
                    got_data_q <= 1'b0;
                end else if (byte_valid_i) begin
                    case (phase_q)
                        PH_SEL: begin
                            if (byte_i[7:1] == DEV_SEL) begin
                                ack_o   <= 1'b1;
                                phase_q <= byte_i[0] ? PH_IDLE : PH_AHI;
                            end else begin
                                phase_q <= PH_IDLE;
                            end
                        end
                        PH_AHI: begin
                            addr_hi_q <= byte_i;
                            ack_o     <= 1'b1;
                            phase_q   <= PH_ALO;
                        end
                        PH_ALO: begin
                            ptr_q   <= word_addr[ADDR_W-1:0];
                            ack_o   <= 1'b1;
                            phase_q <= PH_DATA;
                        end
                        PH_DATA: begin
                            ack_o      <= 1'b1;
                            got_data_q <= 1'b1;
                            ptr_q      <= {ptr_q[ADDR_W-1:PAGE_W],
                                           ptr_q[PAGE_W-1:0] + SLOT_STEP};
                        end
                        default: phase_q <= PH_IDLE;
                    endcase
                end
            end
        end
    end

    // Buffer steering and commit request, qualified by the idle-bus condition.
    always_comb begin
        buf_clear_o  = live && byte_valid_i && !start_i && !stop_i && (phase_q == PH_ALO);
        buf_we_o     = live && byte_valid_i && !start_i && !stop_i && (phase_q == PH_DATA);
        buf_slot_o   = ptr_q[PAGE_W-1:0];
        buf_data_o   = byte_i;
        commit_o     = live && stop_i && (phase_q == PH_DATA) && got_data_q;
        data_phase_o = (phase_q == PH_DATA);
        ptr_o        = ptr_q;
    end

endmodule

// File: rtl/eeprom_pw_pagebuf.sv
// One-page staging buffer with a per-slot received mask.
// Assumes clear and write never coincide; the mask is reset, slot data is not.
module eeprom_pw_pagebuf #(
    parameter int unsigned PAGE_W = 6,
    localparam int unsigned PAGE_N = 1 << PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              we_i,
    input  logic [PAGE_W-1:0] slot_i,
    input  logic [7:0]        data_i,
    output logic [PAGE_N*8-1:0] data_o,
    output logic [PAGE_N-1:0]   mask_o
);

    for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
        logic [7:0] byte_q;
        logic       hit;

        assign hit = we_i && (slot_i == PAGE_W'(g));

        // Received flag for this slot: cleared per transfer, set on write.
        always_ff @(posedge clk) begin
            if (!rst_n)       mask_o[g] <= 1'b0;
            else if (clear_i) mask_o[g] <= 1'b0;
            else if (hit)     mask_o[g] <= 1'b1;
        end

        // Slot storage: last written byte wins.
        always_ff @(posedge clk) begin
            if (hit) byte_q <= data_i;
        end

        assign data_o[g*8 +: 8] = byte_q;
    end

endmodule

// File: rtl/eeprom_pw_timer.sv
// Program-cycle timer: holds busy for WR_CYCLES cycles after a commit
// request, latches the target page, and fires the array write on the
// last busy cycle. Assumes WR_CYCLES >= 1 and no request while busy.
module eeprom_pw_timer #(
    parameter int unsigned WR_CYCLES = 1000,
    parameter int unsigned PG_W      = 5,
    localparam int unsigned CNT_W    = $clog2(WR_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic [PG_W-1:0] page_i,
    output logic            busy_o,
    output logic            fire_o,
    output logic [PG_W-1:0] page_o
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WR_CYCLES);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Countdown and page latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            page_o <= '0;
        end else if (req_i && cnt_q == '0) begin
            cnt_q  <= LOAD;
            page_o <= page_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign busy_o = (cnt_q != '0);
    assign fire_o = (cnt_q == ONE);

endmodule

// File: rtl/eeprom_pw_array.sv
// Storage array: whole-page masked write in one clock, combinational read.
// Contents are not reset.
module eeprom_pw_array #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned PAGE_W = 6,
    localparam int unsigned DEPTH  = 1 << ADDR_W,
    localparam int unsigned PAGE_N = 1 << PAGE_W,
    localparam int unsigned PG_W   = ADDR_W - PAGE_W
) (
    input  logic                clk,
    input  logic                fire_i,
    input  logic [PG_W-1:0]     page_i,
    input  logic [PAGE_N*8-1:0] data_i,
    input  logic [PAGE_N-1:0]   mask_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [7:0]          rd_data_o
);

    logic [7:0] mem [DEPTH];

    // Page commit: every received slot lands on the same edge.
    always_ff @(posedge clk) begin
        if (fire_i) begin
            for (int i = 0; i < PAGE_N; i++) begin
                if (mask_i[i]) mem[{page_i, PAGE_W'(i)}] <= data_i[i*8 +: 8];
            end
        end
    end

    assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/eeprom_page_writer.sv
// Top: byte-level write engine of a two-wire serial EEPROM target.
// Stages one page, commits it on stop during a timed busy window, and
// refuses all bus traffic while busy. Assumes the front end never pulses
// start, stop and a byte strobe in the same cycle.
module eeprom_page_writer #(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned PAGE_W    = 6,
    parameter int unsigned WR_CYCLES = 1000,
    parameter logic [6:0]  DEV_SEL   = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    output logic              ack_valid_o,
    output logic              ack_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);

    localparam int unsigned PAGE_N = 1 << PAGE_W;
    localparam int unsigned PG_W   = ADDR_W - PAGE_W;

    logic                buf_clear, buf_we, commit_req, fire, data_phase;
    logic [PAGE_W-1:0]   buf_slot;
    logic [7:0]          buf_byte;
    logic [PAGE_N*8-1:0] page_data;
    logic [PAGE_N-1:0]   page_mask;
    logic [PG_W-1:0]     commit_page;

    eeprom_pw_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEV_SEL(DEV_SEL)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .stop_i(stop_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .busy_i(busy_o),
        .ack_valid_o(ack_valid_o), .ack_o(ack_o),
        .ptr_o(cur_addr_o), .data_phase_o(data_phase),
        .buf_clear_o(buf_clear), .buf_we_o(buf_we),
        .buf_slot_o(buf_slot), .buf_data_o(buf_byte),
        .commit_o(commit_req)
    );

    eeprom_pw_pagebuf #(.PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clear_i(buf_clear), .we_i(buf_we),
        .slot_i(buf_slot), .data_i(buf_byte),
        .data_o(page_data), .mask_o(page_mask)
    );

    eeprom_pw_timer #(.WR_CYCLES(WR_CYCLES), .PG_W(PG_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .req_i(commit_req), .page_i(cur_addr_o[ADDR_W-1:PAGE_W]),
        .busy_o(busy_o), .fire_o(fire), .page_o(commit_page)
    );

    eeprom_pw_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk(clk), .fire_i(fire), .page_i(commit_page),
        .data_i(page_data), .mask_i(page_mask),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

endmodule

// File: rtl/eeprom_pw_checker.sv
// Checker for eeprom_page_writer: per-cycle protocol and timing properties.
// Attached by the bind statement at the end of this file.
module eeprom_pw_checker #(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned PAGE_W    = 6,
    parameter int unsigned WR_CYCLES = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic              byte_valid_i,
    input logic              ack_valid_o,
    input logic              ack_o,
    input logic              busy_o,
    input logic [ADDR_W-1:0] cur_addr_o,
    input logic              data_phase
);

    int unsigned busy_run;

    // Length of the current busy run, counted in sampled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_run <= 0;
        else if (busy_o) busy_run <= busy_run + 1;
        else             busy_run <= 0;
    end

    a_r1_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_i |=> ack_valid_o);

    a_r12_no_unprompted_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid_i |=> !ack_valid_o);

    a_r8_refuse_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && byte_valid_i) |=> (ack_valid_o && !ack_o));

    a_r8_addr_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(cur_addr_o));

    a_r7_busy_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(busy_o)) |-> (busy_run == WR_CYCLES));

    a_r3_in_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_i && data_phase && !busy_o && !start_i && !stop_i) |=>
        ((cur_addr_o[ADDR_W-1:PAGE_W] == $past(cur_addr_o[ADDR_W-1:PAGE_W])) &&
         (cur_addr_o[PAGE_W-1:0] == PAGE_W'($past(cur_addr_o[PAGE_W-1:0]) + 1'b1))));

endmodule

bind eeprom_page_writer eeprom_pw_checker #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_valid_i(byte_valid_i), .ack_valid_o(ack_valid_o), .ack_o(ack_o),
    .busy_o(busy_o), .cur_addr_o(cur_addr_o), .data_phase(data_phase)
);

// File: tb/eeprom_page_writer_tb.sv
// Self-checking bench: page sweeps, rollover, partial pages, aborts, polling.
module eeprom_page_writer_tb;

    localparam int ADDR_W = 11;
    localparam int PAGE_W = 6;
    localparam int PN     = 1 << PAGE_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WR     = 20;
    localparam logic [6:0] DEV = 7'h50;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0, stop_i = 1'b0, byte_valid_i = 1'b0;
    logic [7:0]        byte_i = '0;
    logic              ack_valid_o, ack_o, busy_o;
    logic [ADDR_W-1:0] cur_addr_o;
    logic [ADDR_W-1:0] rd_addr_i = '0;
    logic [7:0]        rd_data_o;

    eeprom_page_writer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR), .DEV_SEL(DEV)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .ack_valid_o(ack_valid_o), .ack_o(ack_o), .busy_o(busy_o),
        .cur_addr_o(cur_addr_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] ref_mem [DEPTH];
    bit         known   [DEPTH];
    logic [7:0] stage   [PN];
    bit         staged  [PN];

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(output int edge_no);
        @(negedge clk); start_i = 1'b1; edge_no = cyc + 1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic pulse_stop(output int edge_no);
        @(negedge clk); stop_i = 1'b1; edge_no = cyc + 1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        @(negedge clk); byte_valid_i = 1'b1; byte_i = b;
        @(negedge clk); byte_valid_i = 1'b0;
        chk(req, "byte response", {30'd0, ack_valid_o, ack_o}, {30'd0, 1'b1, exp_ack});
    endtask

    // Open a write transfer to addr; hi_fill sets ignored high-byte bits.
    task automatic open_write(input int addr, input logic [7:0] hi_fill);
        int e;
        pulse_start(e);
        send_byte({DEV, 1'b0}, 1'b1, "R1");
        send_byte(8'((addr >> 8) | hi_fill), 1'b1, "R2");
        send_byte(8'(addr & 255), 1'b1, "R2");
        chk("R2", "loaded address", int'(cur_addr_o), addr);
        for (int s = 0; s < PN; s++) staged[s] = 1'b0;
    endtask

    task automatic send_data(input int addr, input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            int slot;
            v = 8'((seed + k * 37) & 255);
            slot = (addr + k) % PN;
            send_byte(v, 1'b1, "R3");
            stage[slot] = v; staged[slot] = 1'b1;
            chk("R3", "in-page pointer", int'(cur_addr_o),
                (addr & ~(PN - 1)) | ((addr + k + 1) % PN));
        end
    endtask

    task automatic model_commit(input int addr);
        for (int s = 0; s < PN; s++) if (staged[s]) begin
            ref_mem[(addr & ~(PN - 1)) + s] = stage[s];
            known[(addr & ~(PN - 1)) + s] = 1'b1;
        end
    endtask

    task automatic wait_busy(input string req);
        int n = 0;
        while (busy_o && n < 1000) begin n++; @(negedge clk); end
        chk(req, "busy length", n, WR);
    endtask

    task automatic check_mem(input string req, input int lo, input int hi);
        for (int a = lo; a <= hi; a++) if (known[a]) begin
            rd_addr_i = ADDR_W'(a); #1;
            chk(req, $sformatf("array[%0h]", a), int'(rd_data_o), int'(ref_mem[a]));
        end
    endtask

    task automatic stay_idle(input string req);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); chk(req, "busy stays low", int'(busy_o), 0);
        end
    endtask

    task automatic full_write(input int addr, input int n, input int seed, input string req);
        int e;
        open_write(addr, 8'h00);
        send_data(addr, n, seed);
        pulse_stop(e);
        chk("R7", "busy after stop", int'(busy_o), 1);
        model_commit(addr);
        wait_busy("R7");
        check_mem(req, addr & ~(PN - 1), (addr & ~(PN - 1)) + PN - 1);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int e, es, e0, tries;
        bit got;
        for (int a = 0; a < DEPTH; a++) known[a] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7", "reset busy", int'(busy_o), 0);
        chk("R7", "reset ack_valid", int'(ack_valid_o), 0);
        chk("R7", "reset address", int'(cur_addr_o), 0);

        // R12: no transfer open.
        send_byte({DEV, 1'b0}, 1'b0, "R12");
        // R1: wrong select refused, transfer ended.
        pulse_start(e);
        send_byte({DEV ^ 7'h01, 1'b0}, 1'b0, "R1");
        send_byte(8'h00, 1'b0, "R1");
        pulse_stop(e);
        stay_idle("R1");

        // R5 sweep: full pages 0..7, distinct patterns.
        for (int p = 0; p < 8; p++) full_write(p * PN, PN, p * 11 + 5, "R5");
        // R12 after a stop.
        send_byte(8'h33, 1'b0, "R12");

        // R4: rollover from slot 60 of page 5, 70 bytes.
        full_write(5 * PN + 60, 70, 200, "R4");
        check_mem("R4", 4 * PN, 7 * PN - 1);

        // R6: partial page with ignored high-byte bits (R2).
        open_write(2 * PN + 10, 8'hF8);
        send_data(2 * PN + 10, 5, 77);
        pulse_stop(e);
        model_commit(2 * PN + 10);
        wait_busy("R7");
        check_mem("R6", 2 * PN, 3 * PN - 1);

        // R9: dummy write then stop; then aborted by a start.
        open_write(4 * PN + 9, 8'h00);
        pulse_stop(e);
        stay_idle("R9");
        chk("R9", "address kept", int'(cur_addr_o), 4 * PN + 9);
        open_write(4 * PN + 20, 8'h00);
        pulse_start(e);
        send_byte({DEV, 1'b0}, 1'b1, "R9");
        pulse_stop(e);
        stay_idle("R9");
        check_mem("R9", 4 * PN, 5 * PN - 1);

        // R10: data then repeated start then stop: discarded.
        open_write(3 * PN, 8'h00);
        send_data(3 * PN, 3, 9);
        pulse_start(e);
        pulse_stop(e);
        stay_idle("R10");
        check_mem("R10", 3 * PN, 4 * PN - 1);

        // R11: read select acknowledged, no write, later bytes refused.
        pulse_start(e);
        send_byte({DEV, 1'b1}, 1'b1, "R11");
        send_byte(8'h12, 1'b0, "R11");
        pulse_stop(e);
        stay_idle("R11");

        // R8: polling during the program cycle.
        open_write(6 * PN + 3, 8'h00);
        send_data(6 * PN + 3, 8, 140);
        pulse_stop(e0);
        model_commit(6 * PN + 3);
        got = 1'b0;
        tries = 0;
        while (!got && tries < 40) begin
            bit exp;
            tries++;
            pulse_start(es);
            exp = (es - e0) > WR;
            send_byte({DEV, 1'b0}, exp, "R8");
            if (exp) got = 1'b1;
            pulse_stop(e);
        end
        chk("R8", "poll eventually acknowledged", int'(got), 1);
        chk("R8", "poll needed refusals", int'(tries > 1), 1);
        check_mem("R8", 6 * PN, 7 * PN - 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule